// File: doc/BRIEF.md
# Circular Reorder Buffer with Dataflow Dispatch

This block holds in-flight instructions as templates in a circular buffer. Decode hands it renamed instructions in program order. Each source operand is resolved at that moment, or else left waiting on the tag of the entry that will produce it. Any entry whose operands are both present may be sent to a functional unit, even when older entries are still waiting. Results come back on a single shared result bus. Every waiting operand that carries the matching tag captures the value from that bus.

Results leave the buffer in program order and go to the architectural register file. If the oldest entry finishes with a nonzero cause, it is reported as an exception instead. The whole buffer is then emptied in one cycle by pulling the allocate pointer back to the commit pointer, and all rename mappings are dropped. A small rename table maps each architectural register to the tag of its youngest in-flight writer. Sources that have no mapping read the register file through a pair of combinational read ports.

Top module: `rob_dataflow`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `disp_valid`, `cmt_valid` and `exc_valid` are 0.
- R2: An instruction is taken when `alloc_valid` and `alloc_ready` are both high, and it receives `alloc_tag`. Tags are handed out consecutively modulo DEPTH. `alloc_ready` is low while DEPTH-1 entries are held, and also in any cycle in which an exception is being reported.
- R3: At allocation each source is resolved as follows. A register with no rename mapping takes the register-file value. A register mapped to a finished entry takes that entry's result, and so does a register whose producer completes in the same cycle. Any other source waits on the producer's tag.
- R4: An entry is offered on the dispatch port only when it is allocated, not yet started, and both operands are present. At most one entry is offered per cycle. An entry dispatches when `disp_valid` and `disp_ready` are both high, and it is never offered again.
- R5: When several entries are candidates, the one offered is the oldest, counted from the commit pointer.
- R6: A completion (`cmp_valid`, `cmp_tag`, `cmp_data`) fills every waiting operand that holds that tag. The consumer becomes a candidate in the following cycle.
- R7: The oldest entry commits once it has completed with cause 0, at the earliest in the cycle after its completion. A commit drives `cmt_valid` with the entry's tag, destination and result. Commits occur strictly in allocation order, one per cycle.
- R8: When the oldest completed entry has a nonzero cause, `exc_valid` is driven with that entry's tag and cause. All entries are discarded, and the next allocation receives that same tag.
- R9: An exception drops every rename mapping, so sources allocated afterwards read the register file.
- R10: A commit removes a rename mapping only if the mapping still names the committing tag. A younger writer of the same register stays mapped.
- R11: A newly allocated entry can be dispatched in the cycle after its allocation at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_op | input | OP_W | Operation code |
| alloc_rs1 | input | REG_W | First source register |
| alloc_rs2 | input | REG_W | Second source register |
| alloc_rd | input | REG_W | Destination register |
| alloc_ready | output | 1 | Buffer can take an instruction |
| alloc_tag | output | TAG_W | Tag assigned to the offered instruction |
| rf_raddr1 | output | REG_W | Register-file read address, first source |
| rf_raddr2 | output | REG_W | Register-file read address, second source |
| rf_rdata1 | input | DATA_W | Register-file read data, first source |
| rf_rdata2 | input | DATA_W | Register-file read data, second source |
| disp_valid | output | 1 | An entry is offered for execution |
| disp_ready | input | 1 | Functional unit accepts the offered entry |
| disp_tag | output | TAG_W | Tag of the offered entry |
| disp_op | output | OP_W | Operation of the offered entry |
| disp_opa | output | DATA_W | First operand value |
| disp_opb | output | DATA_W | Second operand value |
| cmp_valid | input | 1 | A result is broadcast |
| cmp_tag | input | TAG_W | Tag of the finishing entry |
| cmp_data | input | DATA_W | Result value |
| cmp_cause | input | CAUSE_W | Exception cause, 0 for none |
| cmt_valid | output | 1 | Oldest entry retires this cycle |
| cmt_tag | output | TAG_W | Tag of the retiring entry |
| cmt_rd | output | REG_W | Register-file write address |
| cmt_data | output | DATA_W | Register-file write data |
| exc_valid | output | 1 | Oldest entry raises an exception |
| exc_tag | output | TAG_W | Tag of the excepting entry |
| exc_cause | output | CAUSE_W | Cause of the exception |

## Verification
The bench goes after several corner cases:
- **Full buffer.** It fills the buffer with dispatch blocked. A design that miscounted occupancy would overwrite the oldest entry, or report empty when it is full.
- **Same-cycle completion.** It allocates consumers in the cycle their producer completes. A design that missed this bypass would leave the operand waiting forever.
- **Stale mapping after an exception.** It raises exceptions while younger entries are still waiting. It then checks that later sources see the register file rather than a flushed tag, and that the reused tag restarts at the excepting slot.
- **Release by an older writer.** It commits an older writer of a register that has since been renamed again. A design that released the mapping without comparing tags would hand later consumers a stale register-file value.
- **Dispatch order.** It keeps several ready entries waiting across the pointer wrap. A picker that ignored the commit pointer would offer a younger entry first.

// File: rtl/robdf_pkg.sv
package robdf_pkg;

  // What the oldest entry does in the current cycle
  typedef enum logic [1:0] {
    HD_IDLE   = 2'd0,
    HD_RETIRE = 2'd1,
    HD_TRAP   = 2'd2
  } head_act_e;

endpackage

// File: rtl/robdf_rename.sv
module robdf_rename #(
  parameter int NREG  = 8,
  parameter int TAG_W = 3,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] look1_reg,
  input  logic [REG_W-1:0] look2_reg,
  output logic             look1_vld,
  output logic [TAG_W-1:0] look1_tag,
  output logic             look2_vld,
  output logic [TAG_W-1:0] look2_tag,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             rel_en,
  input  logic [REG_W-1:0] rel_reg,
  input  logic [TAG_W-1:0] rel_tag,
  input  logic             flush
);

  logic [NREG-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [NREG];

  assign look1_vld = vld_q[look1_reg];
  assign look1_tag = tag_q[look1_reg];
  assign look2_vld = vld_q[look2_reg];
  assign look2_tag = tag_q[look2_reg];

  always_comb begin
    vld_d = vld_q;
    if (rel_en && tag_q[rel_reg] == rel_tag) vld_d[rel_reg] = 1'b0;
    if (wr_en) vld_d[wr_reg] = 1'b1;
    if (flush) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_reg] <= wr_tag;
  end

  // R9
  map_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

  // R10
  map_keep_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !flush && vld_q[rel_reg] && tag_q[rel_reg] != rel_tag)
      |=> vld_q[$past(rel_reg)]);

endmodule

// File: rtl/robdf_srcsel.sv
module robdf_srcsel #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic              map_vld,
  input  logic [TAG_W-1:0]  map_tag,
  input  logic              prod_done,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic [DATA_W-1:0] rf_data,
  output logic              present,
  output logic [DATA_W-1:0] value
);

  always_comb begin
    present = 1'b1;
    value   = rf_data;
    if (map_vld) begin
      if (prod_done) begin
        value = prod_data;
      end else if (cmp_valid && cmp_tag == map_tag) begin
        value = cmp_data;
      end else begin
        present = 1'b0;
        value   = DATA_W'(map_tag);
      end
    end
  end

endmodule

// File: rtl/robdf_pick.sv
module robdf_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx
);

  logic [IW-1:0] cand;

  always_comb begin
    found = 1'b0;
    idx   = base;
    cand  = base;
    for (int k = N - 1; k >= 0; k--) begin
      cand = base + IW'(k);
      if (req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end

endmodule

// File: rtl/rob_dataflow.sv
module rob_dataflow
  import robdf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NREG    = 8,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 3,
  parameter int CAUSE_W = 3,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic [REG_W-1:0]   alloc_rs1,
  input  logic [REG_W-1:0]   alloc_rs2,
  input  logic [REG_W-1:0]   alloc_rd,
  output logic               alloc_ready,
  output logic [TAG_W-1:0]   alloc_tag,
  output logic [REG_W-1:0]   rf_raddr1,
  output logic [REG_W-1:0]   rf_raddr2,
  input  logic [DATA_W-1:0]  rf_rdata1,
  input  logic [DATA_W-1:0]  rf_rdata2,
  output logic               disp_valid,
  input  logic               disp_ready,
  output logic [TAG_W-1:0]   disp_tag,
  output logic [OP_W-1:0]    disp_op,
  output logic [DATA_W-1:0]  disp_opa,
  output logic [DATA_W-1:0]  disp_opb,
  input  logic               cmp_valid,
  input  logic [TAG_W-1:0]   cmp_tag,
  input  logic [DATA_W-1:0]  cmp_data,
  input  logic [CAUSE_W-1:0] cmp_cause,
  output logic               cmt_valid,
  output logic [TAG_W-1:0]   cmt_tag,
  output logic [REG_W-1:0]   cmt_rd,
  output logic [DATA_W-1:0]  cmt_data,
  output logic               exc_valid,
  output logic [TAG_W-1:0]   exc_tag,
  output logic [CAUSE_W-1:0] exc_cause
);

  // Per-entry control bits
  logic [DEPTH-1:0] use_q, use_d, exec_q, exec_d;
  logic [DEPTH-1:0] p1_q, p1_d, p2_q, p2_d, pd_q, pd_d;
  logic [TAG_W-1:0] aptr_q, aptr_d, cptr_q, cptr_d;

  // Per-entry payload
  logic [OP_W-1:0]    op_q    [DEPTH];
  logic [REG_W-1:0]   rd_q    [DEPTH];
  logic [DATA_W-1:0]  s1_q    [DEPTH];
  logic [DATA_W-1:0]  s2_q    [DEPTH];
  logic [DATA_W-1:0]  data_q  [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];

  head_act_e        head_act;
  logic             full, alloc_fire, disp_fire, cmp_hit;
  logic [DEPTH-1:0] cap1, cap2, wr_new, ready_vec;

  // Source resolution
  logic [1:0]        map_v, src_p;
  logic [TAG_W-1:0]  map_t [2];
  logic [DATA_W-1:0] rf_d  [2];
  logic [DATA_W-1:0] src_v [2];

  always_comb begin
    head_act = HD_IDLE;
    if (use_q[cptr_q] && pd_q[cptr_q]) begin
      head_act = (cause_q[cptr_q] == '0) ? HD_RETIRE : HD_TRAP;
    end
  end

  assign full        = (aptr_q + TAG_W'(1)) == cptr_q;
  assign alloc_ready = !full && (head_act != HD_TRAP);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = aptr_q;
  assign rf_raddr1   = alloc_rs1;
  assign rf_raddr2   = alloc_rs2;
  assign rf_d[0]     = rf_rdata1;
  assign rf_d[1]     = rf_rdata2;

  robdf_rename #(.NREG(NREG), .TAG_W(TAG_W)) u_rename (
    .clk       (clk),
    .rst_n     (rst_n),
    .look1_reg (alloc_rs1),
    .look2_reg (alloc_rs2),
    .look1_vld (map_v[0]),
    .look1_tag (map_t[0]),
    .look2_vld (map_v[1]),
    .look2_tag (map_t[1]),
    .wr_en     (alloc_fire),
    .wr_reg    (alloc_rd),
    .wr_tag    (aptr_q),
    .rel_en    (head_act == HD_RETIRE),
    .rel_reg   (rd_q[cptr_q]),
    .rel_tag   (cptr_q),
    .flush     (head_act == HD_TRAP)
  );

  for (genvar g = 0; g < 2; g++) begin : g_src
    robdf_srcsel #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_sel (
      .map_vld   (map_v[g]),
      .map_tag   (map_t[g]),
      .prod_done (pd_q[map_t[g]]),
      .prod_data (data_q[map_t[g]]),
      .cmp_valid (cmp_valid),
      .cmp_tag   (cmp_tag),
      .cmp_data  (cmp_data),
      .rf_data   (rf_d[g]),
      .present   (src_p[g]),
      .value     (src_v[g])
    );
  end

  // Dispatch selection
  assign ready_vec = use_q & ~exec_q & p1_q & p2_q;

  robdf_pick #(.N(DEPTH), .IW(TAG_W)) u_pick (
    .req   (ready_vec),
    .base  (cptr_q),
    .found (disp_valid),
    .idx   (disp_tag)
  );

  assign disp_op   = op_q[disp_tag];
  assign disp_opa  = s1_q[disp_tag];
  assign disp_opb  = s2_q[disp_tag];
  assign disp_fire = disp_valid && disp_ready;

  // Commit and exception outputs
  assign cmt_valid = (head_act == HD_RETIRE);
  assign cmt_tag   = cptr_q;
  assign cmt_rd    = rd_q[cptr_q];
  assign cmt_data  = data_q[cptr_q];
  assign exc_valid = (head_act == HD_TRAP);
  assign exc_tag   = cptr_q;
  assign exc_cause = cause_q[cptr_q];

  assign cmp_hit = cmp_valid && use_q[cmp_tag];

  // Write enables per entry
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cap1[i]   = cmp_valid && use_q[i] && !p1_q[i] && (s1_q[i][TAG_W-1:0] == cmp_tag);
      cap2[i]   = cmp_valid && use_q[i] && !p2_q[i] && (s2_q[i][TAG_W-1:0] == cmp_tag);
      wr_new[i] = alloc_fire && (aptr_q == TAG_W'(i));
    end
  end

  // Control next state
  always_comb begin
    use_d  = use_q;
    exec_d = exec_q;
    p1_d   = p1_q | cap1;
    p2_d   = p2_q | cap2;
    pd_d   = pd_q;
    aptr_d = aptr_q;
    cptr_d = cptr_q;
    if (head_act == HD_RETIRE) begin
      use_d[cptr_q] = 1'b0;
      cptr_d        = cptr_q + TAG_W'(1);
    end
    if (disp_fire) exec_d[disp_tag] = 1'b1;
    if (cmp_hit)   pd_d[cmp_tag]    = 1'b1;
    if (alloc_fire) begin
      use_d[aptr_q]  = 1'b1;
      exec_d[aptr_q] = 1'b0;
      pd_d[aptr_q]   = 1'b0;
      p1_d[aptr_q]   = src_p[0];
      p2_d[aptr_q]   = src_p[1];
      aptr_d         = aptr_q + TAG_W'(1);
    end
    if (head_act == HD_TRAP) begin
      use_d  = '0;
      aptr_d = cptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q  <= '0;
      exec_q <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
      pd_q   <= '0;
      aptr_q <= '0;
      cptr_q <= '0;
    end else begin
      use_q  <= use_d;
      exec_q <= exec_d;
      p1_q   <= p1_d;
      p2_q   <= p2_d;
      pd_q   <= pd_d;
      aptr_q <= aptr_d;
      cptr_q <= cptr_d;
    end
  end

  // Payload registers, enabled per entry
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_new[i]) begin
        op_q[i] <= alloc_op;
        rd_q[i] <= alloc_rd;
        s1_q[i] <= src_v[0];
        s2_q[i] <= src_v[1];
      end else begin
        if (cap1[i]) s1_q[i] <= cmp_data;
        if (cap2[i]) s2_q[i] <= cmp_data;
      end
      if (cmp_hit && cmp_tag == TAG_W'(i)) begin
        data_q[i]  <= cmp_data;
        cause_q[i] <= cmp_cause;
      end
    end
  end

  // R2
  alloc_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (aptr_q != cptr_q) && use_q[$past(aptr_q)]);

  // R4
  disp_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> use_q[disp_tag] && !exec_q[disp_tag] && p1_q[disp_tag] && p2_q[disp_tag]);

  // R4
  disp_marks_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> exec_q[$past(disp_tag)]);

  // R6
  cmp_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> pd_q[$past(cmp_tag)]);

  // R7
  cmt_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> !use_q[$past(cmt_tag)] && (cptr_q == $past(cptr_q) + TAG_W'(1)));

  // R8
  trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (use_q == '0) && (aptr_q == cptr_q));

endmodule

// File: tb/rob_dataflow_tb_top.sv
module rob_dataflow_tb_top;
  localparam int DEPTH = 8;
  localparam int NREG  = 8;
  localparam int DW    = 16;
  localparam int OPW   = 3;
  localparam int CW    = 3;
  localparam int TW    = 3;
  localparam int RW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          alloc_valid = 1'b0;
  logic [OPW-1:0] alloc_op = '0;
  logic [RW-1:0] alloc_rs1 = '0, alloc_rs2 = '0, alloc_rd = '0;
  logic          alloc_ready;
  logic [TW-1:0] alloc_tag;
  logic [RW-1:0] rf_raddr1, rf_raddr2;
  logic [DW-1:0] rf_rdata1, rf_rdata2;
  logic          disp_valid, disp_ready = 1'b0;
  logic [TW-1:0] disp_tag;
  logic [OPW-1:0] disp_op;
  logic [DW-1:0] disp_opa, disp_opb;
  logic          cmp_valid = 1'b0;
  logic [TW-1:0] cmp_tag = '0;
  logic [DW-1:0] cmp_data = '0;
  logic [CW-1:0] cmp_cause = '0;
  logic          cmt_valid;
  logic [TW-1:0] cmt_tag;
  logic [RW-1:0] cmt_rd;
  logic [DW-1:0] cmt_data;
  logic          exc_valid;
  logic [TW-1:0] exc_tag;
  logic [CW-1:0] exc_cause;

  // Architectural and speculative golden register state
  logic [DW-1:0] arch  [NREG];
  logic [DW-1:0] sregs [NREG];
  assign rf_rdata1 = arch[rf_raddr1];
  assign rf_rdata2 = arch[rf_raddr2];

  rob_dataflow #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DW), .OP_W(OPW), .CAUSE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_rs1(alloc_rs1),
    .alloc_rs2(alloc_rs2), .alloc_rd(alloc_rd), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .rf_raddr1(rf_raddr1), .rf_raddr2(rf_raddr2),
    .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_opa(disp_opa), .disp_opb(disp_opb),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_cause(cmp_cause),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_rd(cmt_rd), .cmt_data(cmt_data),
    .exc_valid(exc_valid), .exc_tag(exc_tag), .exc_cause(exc_cause)
  );

  // Reference model: program-order queue of tags plus per-tag records
  int q[$];
  int pend[$];
  logic [OPW-1:0] m_op  [DEPTH];
  logic [RW-1:0]  m_rd  [DEPTH];
  logic [DW-1:0]  m_ea  [DEPTH];
  logic [DW-1:0]  m_eb  [DEPTH];
  logic [DW-1:0]  m_res [DEPTH];
  int m_cause [DEPTH];
  bit m_disp  [DEPTH];
  int m_done  [DEPTH];
  int m_rc1   [DEPTH];
  int m_rc2   [DEPTH];
  int m_pr1   [DEPTH];
  int m_pr2   [DEPTH];
  int m_sched [DEPTH];
  int aptr = 0;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] calc(logic [OPW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a ^ b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return (a << 1) ^ b;
      default: return a + b + 16'd1;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // One clock cycle: drive at the falling edge, check, advance model, wait
  task automatic step(int alloc_pct, int rdy_pct, int exc_pct);
    int ci;
    int head;
    bit head_done, e_exc, e_cmt, e_ready;
    int e_dt;
    int t;
    int pr;
    ci = -1;
    for (int k = 0; k < pend.size(); k++) begin
      if (ci < 0 && m_sched[pend[k]] <= cyc) ci = k;
    end
    cmp_valid = (ci >= 0);
    if (ci >= 0) begin
      cmp_tag   = TW'(pend[ci]);
      cmp_data  = m_res[pend[ci]];
      cmp_cause = CW'(m_cause[pend[ci]]);
    end
    alloc_valid = ($urandom_range(0, 99) < alloc_pct);
    alloc_op    = OPW'($urandom_range(0, 7));
    alloc_rs1   = RW'($urandom_range(0, NREG - 1));
    alloc_rs2   = RW'($urandom_range(0, NREG - 1));
    alloc_rd    = RW'($urandom_range(0, NREG - 1));
    disp_ready  = ($urandom_range(0, 99) < rdy_pct);
    #1;
    head = (q.size() > 0) ? q[0] : -1;
    head_done = (head >= 0) && (m_done[head] >= 0) && (m_done[head] < cyc);
    e_exc   = head_done && (m_cause[head] != 0);
    e_cmt   = head_done && (m_cause[head] == 0);
    e_ready = (q.size() < DEPTH - 1) && !e_exc;
    // R2: capacity and exception blocking
    chk(alloc_ready == e_ready, "R2", "alloc_ready", int'(alloc_ready), int'(e_ready));
    if (e_ready) chk(int'(alloc_tag) == aptr, "R2", "alloc_tag", int'(alloc_tag), aptr);
    // R7: in-order retirement
    chk(cmt_valid == e_cmt, "R7", "cmt_valid", int'(cmt_valid), int'(e_cmt));
    if (e_cmt && cmt_valid) begin
      chk(int'(cmt_tag) == head, "R7", "cmt_tag", int'(cmt_tag), head);
      chk(cmt_rd == m_rd[head], "R7", "cmt_rd", int'(cmt_rd), int'(m_rd[head]));
      chk(cmt_data == m_res[head], "R7", "cmt_data", int'(cmt_data), int'(m_res[head]));
    end
    // R8: exception report
    chk(exc_valid == e_exc, "R8", "exc_valid", int'(exc_valid), int'(e_exc));
    if (e_exc && exc_valid) begin
      chk(int'(exc_tag) == head, "R8", "exc_tag", int'(exc_tag), head);
      chk(int'(exc_cause) == m_cause[head], "R8", "exc_cause", int'(exc_cause), m_cause[head]);
    end
    // Expected dispatch: oldest entry not started with both operands ready
    e_dt = -1;
    for (int k = 0; k < q.size(); k++) begin
      t = q[k];
      if (e_dt < 0 && !m_disp[t] && m_rc1[t] >= 0 && m_rc1[t] <= cyc
          && m_rc2[t] >= 0 && m_rc2[t] <= cyc) e_dt = t;
    end
    // R4 R11: candidate existence and earliest timing
    chk(disp_valid == (e_dt >= 0), "R4 R11", "disp_valid", int'(disp_valid), int'(e_dt >= 0));
    if (e_dt >= 0 && disp_valid) begin
      // R5: oldest first from the commit pointer
      chk(int'(disp_tag) == e_dt, "R5", "disp_tag", int'(disp_tag), e_dt);
      // R3 R6 R9 R10: operands equal program-order values
      chk(disp_opa == m_ea[e_dt], "R3 R6 R9 R10", "disp_opa", int'(disp_opa), int'(m_ea[e_dt]));
      chk(disp_opb == m_eb[e_dt], "R3 R6 R9 R10", "disp_opb", int'(disp_opb), int'(m_eb[e_dt]));
      chk(disp_op == m_op[e_dt], "R4", "disp_op", int'(disp_op), int'(m_op[e_dt]));
    end
    // Advance the model to the state after the coming edge
    if (e_exc) begin
      aptr = head;
      q.delete();
      pend.delete();
      for (int r = 0; r < NREG; r++) sregs[r] = arch[r];
    end else begin
      if (ci >= 0) begin
        t = pend[ci];
        pend.delete(ci);
        m_done[t] = cyc;
        for (int k = 0; k < q.size(); k++) begin
          if (m_pr1[q[k]] == t && m_rc1[q[k]] < 0) m_rc1[q[k]] = cyc + 1;
          if (m_pr2[q[k]] == t && m_rc2[q[k]] < 0) m_rc2[q[k]] = cyc + 1;
        end
      end
      if (e_cmt) begin
        arch[m_rd[head]] = m_res[head];
        void'(q.pop_front());
      end
      if (e_dt >= 0 && disp_valid && disp_ready) begin
        m_disp[e_dt]  = 1;
        m_sched[e_dt] = cyc + 1 + $urandom_range(0, 3);
        pend.push_back(e_dt);
      end
      if (alloc_valid && e_ready) begin
        t = aptr;
        m_op[t] = alloc_op;
        m_rd[t] = alloc_rd;
        pr = -1;
        for (int k = 0; k < q.size(); k++) if (m_rd[q[k]] == alloc_rs1) pr = q[k];
        m_pr1[t] = pr;
        m_rc1[t] = (pr < 0 || m_done[pr] >= 0) ? cyc + 1 : -1;
        pr = -1;
        for (int k = 0; k < q.size(); k++) if (m_rd[q[k]] == alloc_rs2) pr = q[k];
        m_pr2[t] = pr;
        m_rc2[t] = (pr < 0 || m_done[pr] >= 0) ? cyc + 1 : -1;
        m_ea[t]  = sregs[alloc_rs1];
        m_eb[t]  = sregs[alloc_rs2];
        m_res[t] = calc(alloc_op, m_ea[t], m_eb[t]);
        m_cause[t] = ($urandom_range(0, 99) < exc_pct) ? $urandom_range(1, 7) : 0;
        sregs[alloc_rd] = m_res[t];
        m_disp[t] = 0;
        m_done[t] = -1;
        q.push_back(t);
        aptr = (aptr + 1) % DEPTH;
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin
      arch[r]  = DW'(r * 37 + 5);
      sregs[r] = arch[r];
    end
    for (int i = 0; i < DEPTH; i++) begin
      m_done[i] = -1;
      m_disp[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: empty state after reset
    chk(alloc_ready == 1'b1, "R1", "alloc_ready", int'(alloc_ready), 1);
    chk(alloc_tag == '0, "R1", "alloc_tag", int'(alloc_tag), 0);
    chk(disp_valid == 1'b0, "R1", "disp_valid", int'(disp_valid), 0);
    chk(cmt_valid == 1'b0, "R1", "cmt_valid", int'(cmt_valid), 0);
    chk(exc_valid == 1'b0, "R1", "exc_valid", int'(exc_valid), 0);
    @(negedge clk);
    // Fill to capacity with dispatch held off (R2 full boundary)
    repeat (16) step(100, 0, 0);
    // Drain partly, then mixed traffic with exceptions
    repeat (40) step(0, 100, 0);
    repeat (3000) step(60, 70, 4);
    repeat (1500) step(90, 90, 0);
    repeat (1500) step(80, 40, 8);
    repeat (80) step(0, 100, 0);
    finish_run();
  end

endmodule